// File: doc/BRIEF.md
# Fall-Through FIFO with Handshake Flags

A first-in first-out buffer of `DEPTH` words (16 by default), each `WIDTH` bits wide (5 by default), built as a chain of storage stages. Every stage holds one word and a valid tag. A word enters at the input end and moves one stage per core clock toward the output end while the stage ahead is empty. Fill state is never counted. The writer sees only an input-ready flag and the reader sees only an output-ready flag. A one-cycle low-going pulse reports each time the input-end stage hands its word on, so several buffers can be chained for depth.

All control strobes arrive as plain levels and are sampled by one core clock. Each passes through a two-flop synchronizer, and its edges are found after that synchronizer.
- A write is a rising edge on either of two interchangeable load inputs while the other one is high. One load input can act as a gate and the other as the clock.
- A read is a low pulse on the unload input, which idles high. The word leaves on the return to high.

Back-pressure rules:
- The writer may strobe only while `in_rdy` is high. A strobe while it is low is dropped.
- The reader may pull `unload_in` low only while `out_rdy` is high. A pulse begun while it is low removes nothing.

An active-low clear empties the buffer on its falling edge. An active-low output enable releases the data bus without disturbing anything else.

Top module: `ripple_fifo`

## Requirements
- R1: Words leave in the order they were accepted, and each leaves bit-for-bit equal to its written value (no inversion).
- R2: A word is accepted on a rising edge of `load_a` while `load_b` is high, or on a rising edge of `load_b` while `load_a` is high. A rising edge on one load input while the other is low stores nothing.
- R3: `in_rdy` is high exactly when the input-end stage is empty, and it comes out of reset high. After `DEPTH` writes with no reads it is low. Any write strobed while it is low is discarded and never reaches the output.
- R4: `out_rdy` is high only while the output-end stage holds a word and `unload_in` is high. Once `unload_in` falls, `out_rdy` stays low until a new word reaches the output-end stage. It is low after reset.
- R5: An unload pulse that starts while `out_rdy` is low removes nothing. A word that arrives later is still delivered.
- R6: `unload_out_n` idles high. It goes low for exactly one core clock cycle each time the input-end stage passes its word forward.
- R7: A falling edge on `clr_n` discards every stored word. Afterwards `out_rdy` is low, `in_rdy` is high, and the next word written is the next one read.
- R8: While `oe_n` is high, `dout` is high impedance and every flag keeps operating. While `oe_n` is low, `dout` drives the output-end word.
- R9: A word written into an empty buffer raises `out_rdy` exactly `DEPTH+2` core clock cycles after the load edge is applied: two synchronizer cycles, one capture cycle and `DEPTH-1` moves.
- R10: Three instances chained form one deeper buffer with no loss and no duplication. In the chain, `out_rdy` of one drives `load_a` of the next (with `load_b` held high), `dout` drives the next `din`, and the next `unload_out_n` drives this `unload_in`. With no reads, the chain accepts exactly `3*DEPTH-2` words before its first `in_rdy` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that samples every strobe |
| rst_n | input | 1 | Active-low asynchronous core reset |
| load_a | input | 1 | Load strobe A; interchangeable with load_b as gate or clock |
| load_b | input | 1 | Load strobe B; interchangeable with load_a as gate or clock |
| unload_in | input | 1 | Unload strobe, idles high; a word leaves on its return to high |
| clr_n | input | 1 | Clear strobe, acts on its falling edge |
| oe_n | input | 1 | Active-low enable of the data output drivers |
| din | input | WIDTH | Word to store |
| dout | output | WIDTH | Output-end word, or high impedance |
| in_rdy | output | 1 | Input-end stage is empty |
| out_rdy | output | 1 | Output-end word is valid and may be unloaded |
| unload_out_n | output | 1 | One-cycle low pulse when the input-end stage passes its word forward |

## Verification
- Gating of the load inputs: the bench strobes each load input with the other held low, then raises the held-low input. A design that ignores the gate would store the first word, and a design that treats the inputs unequally would lose one of the two words.
- Full buffer: the bench fills the buffer, tries one more write and then drains it. A stray extra word at the end shows an overflow.
- Latency and pulse timing: a single word is timed through an empty buffer to the exact cycle. The pulse on `unload_out_n` is counted to catch a stretched or missing pulse.
- Unload protocol: the bench unloads an empty buffer, holds `unload_in` low, and clears mid-flight. A design with a wrong arming rule or clear would pop a phantom word, or keep `out_rdy` high while the pulse is in progress or after a clear.
- Chained depth: three chained instances are filled and drained in order. Any duplicated or dropped word changes the accepted count or breaks the order.

// File: rtl/ripple_fifo_pkg.sv
`timescale 1ns/1ps
package ripple_fifo_pkg;

  // Edge and level view of one synchronized strobe
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } strobe_ev_t;

  // Strobe slots inside the top level
  localparam int unsigned STB_LOAD_A = 0;
  localparam int unsigned STB_LOAD_B = 1;
  localparam int unsigned STB_UNLOAD = 2;
  localparam int unsigned STB_CLEAR  = 3;
  localparam int unsigned STB_COUNT  = 4;

endpackage

// File: rtl/ripple_strobe_sync.sv
`timescale 1ns/1ps
module ripple_strobe_sync
  import ripple_fifo_pkg::*;
#(
  parameter int unsigned FLOPS = 2,
  parameter logic        IDLE  = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  output strobe_ev_t ev
);

  localparam int unsigned TAP_NOW  = FLOPS - 1;
  localparam int unsigned TAP_PREV = FLOPS;

  // FLOPS synchronizer flops plus one history flop for edge detection
  logic [FLOPS:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= {(FLOPS + 1){IDLE}};
    else        shreg <= {shreg[FLOPS-1:0], strobe};
  end

  assign ev.level = shreg[TAP_NOW];
  assign ev.rise  = shreg[TAP_NOW] & ~shreg[TAP_PREV];
  assign ev.fall  = ~shreg[TAP_NOW] & shreg[TAP_PREV];

endmodule

// File: rtl/ripple_stage.sv
`timescale 1ns/1ps
module ripple_stage #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             offer,
  input  logic [WIDTH-1:0] offer_dat,
  input  logic             drain,
  output logic             vld,
  output logic [WIDTH-1:0] dat,
  output logic             take
);

  // Only an empty stage takes a word, so take and drain never coincide
  assign take = offer & ~vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           vld <= 1'b0;
    else if (flush)       vld <= 1'b0;
    else if (vld & drain) vld <= 1'b0;
    else if (take)        vld <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dat <= '0;
    else if (take) dat <= offer_dat;
  end

endmodule

// File: rtl/ripple_unload_ctrl.sv
`timescale 1ns/1ps
module ripple_unload_ctrl
  import ripple_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strobe_ev_t ev_unload,
  input  logic       head_vld,
  input  logic       clr_fire,
  output logic       rd_fire,
  output logic       out_rdy
);

  // Armed when unload falls while a word waits at the output end
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              armed <= 1'b0;
    else if (clr_fire)                       armed <= 1'b0;
    else if (ev_unload.fall && head_vld)     armed <= 1'b1;
    else if (ev_unload.rise)                 armed <= 1'b0;
  end

  assign rd_fire = ev_unload.rise & armed & ~clr_fire;
  assign out_rdy = head_vld & ev_unload.level & ~armed;

endmodule

// File: rtl/ripple_fifo.sv
`timescale 1ns/1ps
module ripple_fifo
  import ripple_fifo_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned WIDTH      = 5,
  parameter int unsigned SYNC_FLOPS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_a,
  input  logic             load_b,
  input  logic             unload_in,
  input  logic             clr_n,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             in_rdy,
  output logic             out_rdy,
  output logic             unload_out_n
);

  localparam int unsigned LAST = DEPTH - 1;

  // ---------------- strobe synchronizers ----------------
  logic [STB_COUNT-1:0] strobe_raw;
  strobe_ev_t           ev [STB_COUNT];

  assign strobe_raw[STB_LOAD_A] = load_a;
  assign strobe_raw[STB_LOAD_B] = load_b;
  assign strobe_raw[STB_UNLOAD] = unload_in;
  assign strobe_raw[STB_CLEAR]  = clr_n;

  for (genvar s = 0; s < STB_COUNT; s++) begin : g_sync
    ripple_strobe_sync #(
      .FLOPS (SYNC_FLOPS),
      .IDLE  (1'b1)
    ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobe_raw[s]),
      .ev     (ev[s])
    );
  end

  // ---------------- write / clear decode ----------------
  logic clr_fire;
  logic wr_fire;

  assign clr_fire = ev[STB_CLEAR].fall;
  assign wr_fire  = ((ev[STB_LOAD_A].rise & ev[STB_LOAD_B].level) |
                     (ev[STB_LOAD_B].rise & ev[STB_LOAD_A].level)) & ~clr_fire;

  // ---------------- stage chain ----------------
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] take;
  logic [DEPTH-1:0] drain;
  logic [DEPTH-1:0] offer;
  logic [WIDTH-1:0] dat       [DEPTH];
  logic [WIDTH-1:0] offer_dat [DEPTH];
  logic             rd_fire;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == LAST) begin : g_input_end
      assign offer[i]     = wr_fire;
      assign offer_dat[i] = din;
    end else begin : g_inner_in
      assign offer[i]     = vld[i+1];
      assign offer_dat[i] = dat[i+1];
    end

    if (i == 0) begin : g_output_end
      assign drain[i] = rd_fire;
    end else begin : g_inner_out
      assign drain[i] = take[i-1];
    end

    ripple_stage #(
      .WIDTH (WIDTH)
    ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (clr_fire),
      .offer     (offer[i]),
      .offer_dat (offer_dat[i]),
      .drain     (drain[i]),
      .vld       (vld[i]),
      .dat       (dat[i]),
      .take      (take[i])
    );
  end

  // ---------------- unload side ----------------
  ripple_unload_ctrl u_unload (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_unload (ev[STB_UNLOAD]),
    .head_vld  (vld[0]),
    .clr_fire  (clr_fire),
    .rd_fire   (rd_fire),
    .out_rdy   (out_rdy)
  );

  // ---------------- input-end vacancy pulse ----------------
  logic vacate_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vacate_q_n <= 1'b1;
    else        vacate_q_n <= ~(vld[LAST] & drain[LAST] & ~clr_fire);
  end

  assign unload_out_n = vacate_q_n;
  assign in_rdy       = ~vld[LAST];
  assign dout         = oe_n ? {WIDTH{1'bz}} : dat[0];

  logic unused_bits;
  assign unused_bits = ^{ev[STB_LOAD_A].fall, ev[STB_LOAD_B].fall,
                         ev[STB_CLEAR].rise, ev[STB_CLEAR].level, take[LAST]};

endmodule

// File: rtl/ripple_fifo_chk.sv
`timescale 1ns/1ps
module ripple_fifo_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_rdy,
  input logic             out_rdy,
  input logic             unload_out_n,
  input logic [DEPTH-1:0] vld,
  input logic             rd_fire,
  input logic             clr_fire
);

  AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(vld) == DEPTH) |-> !in_rdy); // R3

  AST_NO_GROWTH_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rdy |=> ($countones(vld) <= $past($countones(vld)))); // R3

  AST_VACATE_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !unload_out_n |=> unload_out_n); // R6

  AST_POP_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !out_rdy); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> (vld == '0 && !out_rdy && in_rdy)); // R7

endmodule

bind ripple_fifo ripple_fifo_chk #(
  .DEPTH (DEPTH)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_rdy       (in_rdy),
  .out_rdy      (out_rdy),
  .unload_out_n (unload_out_n),
  .vld          (vld),
  .rd_fire      (rd_fire),
  .clr_fire     (clr_fire)
);

// File: tb/ripple_fifo_tb_top.sv
`timescale 1ns/1ps
module ripple_fifo_tb_top;

  localparam int DEPTH = 16;
  localparam int WIDTH = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // ---------------- single instance ----------------
  logic             load_a = 1'b1, load_b = 1'b1, unload = 1'b1, clr_n = 1'b1, oe_n = 1'b0;
  logic [WIDTH-1:0] din = '0;
  wire  [WIDTH-1:0] bus;
  logic             drv_en = 1'b0;
  logic [WIDTH-1:0] drv_val = '0;
  logic             in_rdy, out_rdy, uo_n;

  assign bus = drv_en ? drv_val : {WIDTH{1'bz}};

  ripple_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_a(load_a), .load_b(load_b),
    .unload_in(unload), .clr_n(clr_n), .oe_n(oe_n), .din(din),
    .dout(bus), .in_rdy(in_rdy), .out_rdy(out_rdy), .unload_out_n(uo_n));

  // ---------------- three-deep chain ----------------
  logic             cas_load = 1'b1, cas_unload = 1'b1;
  logic [WIDTH-1:0] cas_din = '0;
  wire  [WIDTH-1:0] d01, d12, d2o;
  wire              or0, or1, or2, ir0, ir1, ir2, uo0, uo1, uo2;

  ripple_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) cas0 (
    .clk(clk), .rst_n(rst_n), .load_a(cas_load), .load_b(1'b1),
    .unload_in(uo1), .clr_n(1'b1), .oe_n(1'b0), .din(cas_din),
    .dout(d01), .in_rdy(ir0), .out_rdy(or0), .unload_out_n(uo0));
  ripple_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) cas1 (
    .clk(clk), .rst_n(rst_n), .load_a(or0), .load_b(1'b1),
    .unload_in(uo2), .clr_n(1'b1), .oe_n(1'b0), .din(d01),
    .dout(d12), .in_rdy(ir1), .out_rdy(or1), .unload_out_n(uo1));
  ripple_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) cas2 (
    .clk(clk), .rst_n(rst_n), .load_a(or1), .load_b(1'b1),
    .unload_in(cas_unload), .clr_n(1'b1), .oe_n(1'b0), .din(d12),
    .dout(d2o), .in_rdy(ir2), .out_rdy(or2), .unload_out_n(uo2));

  logic [WIDTH-1:0] exp_q[$];
  logic [WIDTH-1:0] cas_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: strobe load_a with load_b high; record expected word if accepted
  task automatic push(input logic [WIDTH-1:0] d);
    din = d;
    load_a = 1'b0;
    repeat (3) @(negedge clk);
    if (in_rdy) exp_q.push_back(d);
    load_a = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // Monitor: wait for a word, compare against the scoreboard, unload it
  task automatic pop_check(input string req);
    int w = 0;
    while (!out_rdy && w < 200) begin @(negedge clk); w++; end
    check(out_rdy === 1'b1, {req, " out_rdy before unload"}, out_rdy, 1);
    if (exp_q.size() == 0) begin
      check(1'b0, {req, " scoreboard empty"}, 0, 1);
    end else begin
      check(bus === exp_q[0], {req, " data"}, bus, exp_q[0]);
      void'(exp_q.pop_front());
    end
    unload = 1'b0;
    repeat (3) @(negedge clk);
    unload = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cas_push(input logic [WIDTH-1:0] d);
    cas_din = d;
    cas_load = 1'b0;
    repeat (3) @(negedge clk);
    if (ir0) cas_q.push_back(d);
    cas_load = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int first;
    int lows;
    int accepted;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Reset state
    check(in_rdy === 1'b1, "R3 reset in_rdy", in_rdy, 1);
    check(out_rdy === 1'b0, "R4 reset out_rdy", out_rdy, 0);
    check(uo_n === 1'b1, "R6 reset unload_out_n", uo_n, 1);

    // R9 latency and R6 pulse width for one word into an empty buffer
    din = 5'h15;
    load_a = 1'b0;
    repeat (3) @(negedge clk);
    exp_q.push_back(5'h15);
    load_a = 1'b1;
    first = 0; lows = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (!uo_n) lows++;
      if (out_rdy && first == 0) first = k;
    end
    check(first == DEPTH + 2, "R9 cycles to out_rdy", first, DEPTH + 2);
    check(lows == 1, "R6 low cycles of unload_out_n", lows, 1);
    pop_check("R1");

    // R2 gating: each load input alone with the other low stores nothing
    load_b = 1'b0;
    din = 5'h0A;
    repeat (3) @(negedge clk);
    load_a = 1'b0;
    repeat (3) @(negedge clk);
    load_a = 1'b1;
    repeat (30) @(negedge clk);
    check(out_rdy === 1'b0, "R2 load_a edge with load_b low ignored", out_rdy, 0);
    exp_q.push_back(5'h0A);
    load_b = 1'b1;                     // rising load_b while load_a high writes
    repeat (5) @(negedge clk);
    pop_check("R2 load_b as clock");
    load_a = 1'b0;
    repeat (3) @(negedge clk);
    load_b = 1'b0;
    repeat (3) @(negedge clk);
    din = 5'h11;
    load_b = 1'b1;
    repeat (30) @(negedge clk);
    check(out_rdy === 1'b0, "R2 load_b edge with load_a low ignored", out_rdy, 0);
    exp_q.push_back(5'h11);
    load_a = 1'b1;
    repeat (5) @(negedge clk);
    pop_check("R2 load_a as clock");

    // R3 fill to capacity, overflow write discarded
    for (int n = 0; n < DEPTH; n++) begin
      check(in_rdy === 1'b1, "R3 in_rdy while filling", in_rdy, 1);
      push(WIDTH'(n * 3 + 1));
    end
    repeat (25) @(negedge clk);
    check(in_rdy === 1'b0, "R3 in_rdy when full", in_rdy, 0);
    push(5'h1F);
    for (int n = 0; n < DEPTH; n++) pop_check("R1 R3 drain");
    repeat (40) @(negedge clk);
    check(out_rdy === 1'b0, "R3 overflow word absent", out_rdy, 0);
    check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);

    // R4 out_rdy gated by unload level and stays low after removal
    push(5'h07);
    repeat (25) @(negedge clk);
    check(out_rdy === 1'b1, "R4 out_rdy with word", out_rdy, 1);
    check(bus === 5'h07, "R1 head data", bus, 5'h07);
    unload = 1'b0;
    repeat (3) @(negedge clk);
    check(out_rdy === 1'b0, "R4 out_rdy while unload low", out_rdy, 0);
    unload = 1'b1;
    repeat (10) @(negedge clk);
    check(out_rdy === 1'b0, "R4 out_rdy low after removal", out_rdy, 0);
    void'(exp_q.pop_front());

    // R5 unload while empty removes nothing
    unload = 1'b0;
    repeat (4) @(negedge clk);
    push(5'h19);                       // arrives while unload is low
    repeat (25) @(negedge clk);
    unload = 1'b1;
    repeat (6) @(negedge clk);
    check(out_rdy === 1'b1, "R5 late word kept after unarmed unload", out_rdy, 1);
    pop_check("R5");
    check(out_rdy === 1'b0, "R5 empty after single read", out_rdy, 0);

    // R8 output enable releases the bus, flags keep working
    push(5'h0C);
    repeat (25) @(negedge clk);
    oe_n = 1'b1;
    drv_val = 5'h13;
    drv_en = 1'b1;
    @(negedge clk);
    check(bus === 5'h13, "R8 bus released while oe_n high", bus, 5'h13);
    check(out_rdy === 1'b1, "R8 out_rdy active while oe_n high", out_rdy, 1);
    drv_en = 1'b0;
    oe_n = 1'b0;
    @(negedge clk);
    check(bus === 5'h0C, "R8 bus driven while oe_n low", bus, 5'h0C);
    pop_check("R8");

    // R7 clear discards stored and in-flight words
    push(5'h01);
    push(5'h02);
    push(5'h03);
    clr_n = 1'b0;
    repeat (4) @(negedge clk);
    clr_n = 1'b1;
    exp_q.delete();
    repeat (2) @(negedge clk);
    check(out_rdy === 1'b0, "R7 out_rdy after clear", out_rdy, 0);
    check(in_rdy === 1'b1, "R7 in_rdy after clear", in_rdy, 1);
    repeat (30) @(negedge clk);
    check(out_rdy === 1'b0, "R7 no word survives clear", out_rdy, 0);
    push(5'h1D);
    pop_check("R7 first word after clear");

    // R10 chained depth: fill without reads, then drain in order
    accepted = 0;
    for (int k = 0; k < 3 * DEPTH + 8; k++) begin
      if (!ir0) begin
        repeat (300) @(negedge clk);
        if (!ir0) break;
      end
      cas_push(WIDTH'(k * 7 + 3));
      accepted++;
    end
    check(accepted == 3 * DEPTH - 2, "R10 words accepted by chain", accepted, 3 * DEPTH - 2);
    while (cas_q.size() > 0) begin
      int w = 0;
      while (!or2 && w < 800) begin @(negedge clk); w++; end
      check(or2 === 1'b1 && d2o === cas_q[0], "R10 chain order", d2o, cas_q[0]);
      void'(cas_q.pop_front());
      cas_unload = 1'b0;
      repeat (3) @(negedge clk);
      cas_unload = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (400) @(negedge clk);
    check(or2 === 1'b0, "R10 no duplicate after drain", or2, 0);
    check(ir0 === 1'b1, "R10 chain input ready after drain", ir0, 1);

    finish_run();
  end

endmodule